// File: doc/BRIEF.md
# Stream-to-memory capture with length report

The block takes one packet from an AXI-Stream input and turns each accepted beat into a word write on a simple memory port. The port carries address, data, byte strobes, valid and ready. Writes start at a programmed 32-bit byte address, and the address advances by one data word for every beat accepted. Capture is armed by a rising edge on the start control bit. It ends on the beat that carries TLAST, or with an error when the next address would pass the top of the 32-bit space.

During capture the block counts the bytes it accepts. On the final beat it counts only the bytes that TKEEP marks valid, so the total is exact. When capture ends, the full count is held in a 32-bit length output, and the low 26 bits of the count also appear in the upper field of the status word. The status word also reports done, a 3-bit error code and two interrupt flags. Each flag has its own enable and stays set until the next start.

Top module: `s2m_capture`

## Requirements
- R1: Capture is armed only on a 0 to 1 transition of `start_i` (control bit 0). Holding `start_i` high after capture ends does not start a new capture.
- R2: `s_tready_o` stays low while no capture is running. This covers beats that arrive before start and beats that arrive after the TLAST beat or after an error stop.
- R3: The first accepted beat is written at `base_addr_i`. Each later beat is written 4 bytes above the one before it. `wr_data_o` equals `s_tdata_i`.
- R4: While a capture runs, `s_tready_o` follows `wr_ready_i` and `wr_valid_o` follows `s_tvalid_i`. `wr_strb_o` is all ones, except on the TLAST beat, where it equals `s_tkeep_i`.
- R5: `rx_len_o` reports the number of bytes accepted from start up to and including the TLAST beat: 4 for each earlier beat, plus the number of set TKEEP bits on the last beat. TKEEP is contiguous from bit 0.
- R6: After the TLAST beat, status bit 0 (done) is 1. Status bits 31:6 hold bits 25:0 of the byte count.
- R7: Status bit 5 (completion flag) is set at done only if `done_ie_i` (control bit 5) is high. It stays set until the next start.
- R8: Suppose an accepted beat other than the TLAST beat leaves the next address past 32 bits. Capture then stops, status bits 3:1 read 1, done stays 0, and status bit 4 (error flag) is set if `err_ie_i` (control bit 4) is high. A TLAST beat at the top word completes normally.
- R9: A start edge clears the status word and `rx_len_o` to 0. The status word and `rx_len_o` are also 0 after reset.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start control bit; capture arms on its rising edge |
| err_ie_i | input | 1 | Error interrupt enable |
| done_ie_i | input | 1 | Completion interrupt enable |
| base_addr_i | input | 32 | Byte address of the first write |
| s_tdata_i | input | 32 | Stream data |
| s_tkeep_i | input | 4 | Stream byte enables |
| s_tlast_i | input | 1 | Last beat of the packet |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Stream beat accepted |
| wr_addr_o | output | 32 | Memory write byte address |
| wr_data_o | output | 32 | Memory write data |
| wr_strb_o | output | 4 | Memory write byte strobes |
| wr_valid_o | output | 1 | Memory write request |
| wr_ready_i | input | 1 | Memory port can take the write |
| status_o | output | 32 | {len[25:0], done flag, error flag, error code[2:0], done} |
| rx_len_o | output | 32 | Byte count of the last capture |
| irq_o | output | 1 | OR of the two interrupt flags |

## Verification
The bench builds the block with its default 32-bit address, 32-bit data and 32-bit count. Random transfers of 1 to 20 beats, with stalls on both sides, exercise the TKEEP-dependent byte count and the per-beat address step. With a 32-bit address, base addresses a few words below the top of memory reach the address-wrap stop within a handful of beats. A TLAST beat at the last word checks the boundary where capture completes without an error.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_WRAP = 3'd1
  } err_e;
endpackage

// File: rtl/s2m_edge_det.sv
module s2m_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/s2m_addr_gen.sv
module s2m_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W:0] STEP_V = (ADDR_W+1)'(STEP);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   nxt;

  assign nxt    = {1'b0, addr_q} + STEP_V;
  assign wrap_o = nxt[ADDR_W];
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (adv_i)  addr_q <= nxt[ADDR_W-1:0];
  end

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> addr_o == $past(addr_o) + STEP_V[ADDR_W-1:0]); // R3
  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(base_i)); // R3
endmodule

// File: rtl/s2m_len_stat.sv
module s2m_len_stat
  import s2m_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int STRB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic [STRB_W-1:0] keep_i,
  input  logic              wrap_i,
  input  logic              err_ie_i,
  input  logic              done_ie_i,
  output logic              done_o,
  output err_e              err_o,
  output logic              err_flag_o,
  output logic              done_flag_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [LEN_W-1:0] beat_bytes;
  logic             wrap_stop;

  always_comb begin
    if (last_i) begin
      beat_bytes = '0;
      for (int i = 0; i < STRB_W; i++) beat_bytes = beat_bytes + LEN_W'(keep_i[i]);
    end else begin
      beat_bytes = LEN_W'(STRB_W);
    end
  end

  assign wrap_stop = fire_i & wrap_i & ~last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      err_o       <= ERR_NONE;
      err_flag_o  <= 1'b0;
      done_flag_o <= 1'b0;
      len_o       <= '0;
    end else if (clear_i) begin
      done_o      <= 1'b0;
      err_o       <= ERR_NONE;
      err_flag_o  <= 1'b0;
      done_flag_o <= 1'b0;
      len_o       <= '0;
    end else if (fire_i) begin
      len_o <= len_o + beat_bytes;
      if (last_i) begin
        done_o <= 1'b1;
        if (done_ie_i) done_flag_o <= 1'b1;
      end
      if (wrap_stop) begin
        err_o <= ERR_WRAP;
        if (err_ie_i) err_flag_o <= 1'b1;
      end
    end
  end

  AST_LEN_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !clear_i |=> len_o > $past(len_o)); // R5
  AST_DONE_FLAG_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> $past(done_ie_i)); // R7
  AST_ERR_FLAG_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> $past(err_ie_i)); // R8
  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == ERR_WRAP |-> !done_o); // R8
endmodule

// File: rtl/s2m_capture.sv
module s2m_capture
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                err_ie_i,
  input  logic                done_ie_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [DATA_W-1:0]   s_tdata_i,
  input  logic [DATA_W/8-1:0] s_tkeep_i,
  input  logic                s_tlast_i,
  input  logic                s_tvalid_i,
  output logic                s_tready_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W/8-1:0] wr_strb_o,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [31:0]         status_o,
  output logic [LEN_W-1:0]    rx_len_o,
  output logic                irq_o
);
  localparam int STRB_W  = DATA_W / 8;
  localparam int FIELD_W = 26;

  logic start_rise, run_q, fire, wrap;
  logic done, err_flag, done_flag;
  err_e err;
  logic [LEN_W-1:0] len;

  s2m_edge_det i_edge (
    .clk_i, .rst_ni, .lvl_i(start_i), .rise_o(start_rise)
  );

  assign s_tready_o = run_q & wr_ready_i;
  assign wr_valid_o = run_q & s_tvalid_i;
  assign wr_data_o  = s_tdata_i;
  assign wr_strb_o  = s_tlast_i ? s_tkeep_i : '1;
  assign fire       = s_tvalid_i & s_tready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_q <= 1'b0;
    else if (start_rise)               run_q <= 1'b1;
    else if (fire && (s_tlast_i || wrap)) run_q <= 1'b0;
  end

  s2m_addr_gen #(.ADDR_W(ADDR_W), .STEP(STRB_W)) i_addr (
    .clk_i, .rst_ni,
    .load_i(start_rise), .base_i(base_addr_i), .adv_i(fire),
    .addr_o(wr_addr_o), .wrap_o(wrap)
  );

  s2m_len_stat #(.LEN_W(LEN_W), .STRB_W(STRB_W)) i_stat (
    .clk_i, .rst_ni,
    .clear_i(start_rise), .fire_i(fire), .last_i(s_tlast_i), .keep_i(s_tkeep_i),
    .wrap_i(wrap), .err_ie_i, .done_ie_i,
    .done_o(done), .err_o(err), .err_flag_o(err_flag), .done_flag_o(done_flag),
    .len_o(len)
  );

  assign rx_len_o = len;
  assign status_o = {len[FIELD_W-1:0], done_flag, err_flag, err, done};
  assign irq_o    = done_flag | err_flag;

  AST_DONE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !s_tready_o); // R2
  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err != ERR_NONE |-> !s_tready_o); // R8
  AST_HELD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && $past(start_i) && start_i |=> !run_q); // R1
endmodule

// File: tb/test_s2m_capture.sv
module test_s2m_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, err_ie_i = 1'b0, done_ie_i = 1'b0;
  logic [31:0] base_addr_i = '0, s_tdata_i = '0;
  logic [3:0]  s_tkeep_i = '0;
  logic        s_tlast_i = 1'b0, s_tvalid_i = 1'b0, wr_ready_i = 1'b0;
  logic        s_tready_o, wr_valid_o, irq_o;
  logic [31:0] wr_addr_o, wr_data_o, status_o, rx_len_o;
  logic [3:0]  wr_strb_o;
  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  s2m_capture i_s2m_capture (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] keep_of(int n);
    return 4'((1 << n) - 1);
  endfunction

  function automatic logic [31:0] exp_status(logic [31:0] len, bit dn, bit er, bit die, bit eie);
    return {len[25:0], dn & die, er & eie, er ? 3'd1 : 3'd0, dn};
  endfunction

  task automatic xfer(logic [31:0] base, int n, int lb, bit die, bit eie, int acc);
    logic [31:0] len;
    bit er;
    int idx = 0, cyc = 0;
    @(negedge clk_i);
    start_i = 1'b0; s_tvalid_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; base_addr_i = base; done_ie_i = die; err_ie_i = eie;
    @(negedge clk_i);
    check("R9 status cleared", status_o, 32'h0);
    check("R9 length cleared", rx_len_o, 32'h0);
    while (idx < acc && cyc < 4000) begin
      s_tvalid_i = ($urandom % 4) != 0;
      s_tdata_i  = $urandom;
      s_tlast_i  = (idx == n - 1);
      s_tkeep_i  = s_tlast_i ? keep_of(lb) : 4'hf;
      wr_ready_i = ($urandom % 3) != 0;
      #1;
      check("R4 ready follows memory", 32'(s_tready_o), 32'(wr_ready_i));
      check("R4 valid follows stream", 32'(wr_valid_o), 32'(s_tvalid_i));
      if (s_tvalid_i && s_tready_o) begin
        check("R3 address", wr_addr_o, base + 32'(4 * idx));
        check("R3 data", wr_data_o, s_tdata_i);
        check("R4 strobe", 32'(wr_strb_o), 32'(s_tkeep_i));
        idx++;
      end
      @(negedge clk_i);
      cyc++;
    end
    s_tvalid_i = 1'b1; s_tlast_i = 1'b0; wr_ready_i = 1'b1; s_tkeep_i = 4'hf;
    er  = (acc < n);
    len = er ? 32'(4 * acc) : 32'(4 * (n - 1) + lb);
    #1;
    check("R5 length", rx_len_o, len);
    check("R6 R7 R8 status", status_o, exp_status(len, !er, er, die, eie));
    check("R7 irq", 32'(irq_o), 32'((!er && die) || (er && eie)));
    for (int k = 0; k < 3; k++) begin
      check("R2 R1 no accept after end, start held", 32'(s_tready_o), 32'h0);
      @(negedge clk_i); #1;
    end
    check("R1 held start keeps length", rx_len_o, len);
    s_tvalid_i = 1'b0; start_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R9 reset status", status_o, 32'h0);
    check("R9 reset length", rx_len_o, 32'h0);
    check("R2 reset ready", 32'(s_tready_o), 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    s_tvalid_i = 1'b1; wr_ready_i = 1'b1;
    @(negedge clk_i); #1;
    check("R2 no accept before start", 32'(s_tready_o), 32'h0);
    s_tvalid_i = 1'b0;
    xfer(32'h0000_1000, 1, 1, 1'b1, 1'b1, 1);
    xfer(32'h0000_2000, 3, 4, 1'b0, 1'b0, 3);
    for (int t = 0; t < 8; t++) begin
      int n = 1 + ($urandom % 20);
      xfer($urandom & 32'h0FFF_FFFC, n, 1 + ($urandom % 4), 1'($urandom), 1'($urandom), n);
    end
    xfer(32'hFFFF_FFF4, 10, 4, 1'b1, 1'b1, 3);
    xfer(32'hFFFF_FFF4, 10, 2, 1'b1, 1'b0, 3);
    xfer(32'hFFFF_FFF8, 2, 3, 1'b1, 1'b1, 2);
    xfer(32'h0000_0040, 5, 2, 1'b1, 1'b0, 5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule